// File: doc/BRIEF.md
# Bus Conflict Stall Sequencer

This control block decides how long a multifunction instruction occupies the pipeline when its memory accesses share banks. Each instruction brings up to three memory items: an instruction fetch and one or two data accesses. For each item the block gets a bank index, along with a flag that says whether the instruction word is already held in the instruction cache. A cache hit takes the fetch out of contention.

After an instruction is accepted, the block counts how many of its live accesses fall on the busiest bank. That count is the number of cycles the instruction needs, from one to three. The block then issues the accesses over those cycles and grants at most one access per bank in each cycle. When accesses collide, the first data access is served first, the second data access next, and the fetch last. The stall output holds the pipeline in every service cycle except the final one, and a done pulse marks that final cycle.

A new request is taken only while the block is idle. Requests that arrive during a sequence have no effect.

Top module: `sbc_stall_seq`

## Requirements
- R1: A request is accepted on a rising edge only when `ready_o` is 1, and `ready_o` is 1 exactly when no access is pending. A request or input change while `ready_o` is 0 does not change the grants, the stall, done or `cycles_o` of the running sequence.
- R2: The live access set is fixed at acceptance. The first data access is always live, the second is live when `dual_i`=1, and the fetch is live when `ic_hit_i`=0. A dead access is never granted.
- R3: In any cycle, no two granted accesses carry the same bank index.
- R4: `cycles_o` takes, from the cycle after acceptance, the largest number of live accesses that share one bank (1, 2 or 3). It holds that value until the next acceptance.
- R5: Among pending accesses on the same bank, the grant order is the first data access, then the second data access, then the fetch. Pending accesses on distinct banks are granted in the same cycle.
- R6: Service starts in the cycle after acceptance and lasts exactly `cycles_o` cycles. `stall_o` is 1 in every service cycle but the last, and `done_o` is 1 only in the last. The block is ready again in the following cycle.
- R7: Each live access is granted in exactly one service cycle, and every service cycle grants at least one access.
- R8: After reset, `ready_o` is 1, `cycles_o` is 0, and all grants, `stall_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | New instruction request |
| dual_i | input | 1 | Instruction has a second data access |
| ic_hit_i | input | 1 | Instruction word hits in the instruction cache |
| fetch_bank_i | input | BANK_W | Bank of the instruction fetch |
| d0_bank_i | input | BANK_W | Bank of the first data access |
| d1_bank_i | input | BANK_W | Bank of the second data access |
| ready_o | output | 1 | Idle, request can be taken |
| stall_o | output | 1 | Hold the pipeline this cycle |
| done_o | output | 1 | Last service cycle of the instruction |
| d0_gnt_o | output | 1 | First data access granted this cycle |
| d1_gnt_o | output | 1 | Second data access granted this cycle |
| fetch_gnt_o | output | 1 | Fetch granted this cycle |
| cycles_o | output | 2 | Cycle count of the current instruction |

## Verification
A request driven before edge P is taken at P. `cycles_o` and the first cycle's grants, stall and done then appear right after P, and each later service cycle follows one edge after the one before it. The bench samples every output on the falling edge inside each service cycle, and it checks `ready_o` one falling edge after the cycle that carried done. All bank, hit and dual combinations for four banks are swept. In half of the runs, altered requests are held high during service to show that they do not disturb the sequence.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int N_ACC = 3;               // d0, d1, fetch
  localparam int CNT_W = $clog2(N_ACC + 1);
  localparam int ACC_D0 = 0;
  localparam int ACC_D1 = 1;
  localparam int ACC_IF = 2;              // lowest priority
endpackage

// File: rtl/sbc_conflict_count.sv
module sbc_conflict_count
  import sbc_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic [N_ACC-1:0]             act_i,
  input  logic [N_ACC-1:0][BANK_W-1:0] bank_i,
  output logic [CNT_W-1:0]             cnt_o
);
  logic [N_ACC-1:0][CNT_W-1:0] mult;

  // per access: live accesses sharing its bank
  for (genvar i = 0; i < N_ACC; i++) begin : g_mult
    always_comb begin
      mult[i] = '0;
      for (int j = 0; j < N_ACC; j++) begin
        if (act_i[i] && act_i[j] && (bank_i[i] == bank_i[j]))
          mult[i] = mult[i] + CNT_W'(1);
      end
    end
  end

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N_ACC; i++) begin
      if (mult[i] > cnt_o) cnt_o = mult[i];
    end
  end
endmodule

// File: rtl/sbc_grant_arb.sv
module sbc_grant_arb
  import sbc_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic [N_ACC-1:0]             pend_i,
  input  logic [N_ACC-1:0][BANK_W-1:0] bank_i,
  output logic [N_ACC-1:0]             gnt_o
);
  // lower index wins its bank
  for (genvar i = 0; i < N_ACC; i++) begin : g_gnt
    logic blocked;
    always_comb begin
      blocked = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (pend_i[j] && (bank_i[j] == bank_i[i])) blocked = 1'b1;
      end
    end
    assign gnt_o[i] = pend_i[i] && !blocked;
  end
endmodule

// File: rtl/sbc_stall_seq.sv
module sbc_stall_seq
  import sbc_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              dual_i,
  input  logic              ic_hit_i,
  input  logic [BANK_W-1:0] fetch_bank_i,
  input  logic [BANK_W-1:0] d0_bank_i,
  input  logic [BANK_W-1:0] d1_bank_i,
  output logic              ready_o,
  output logic              stall_o,
  output logic              done_o,
  output logic              d0_gnt_o,
  output logic              d1_gnt_o,
  output logic              fetch_gnt_o,
  output logic [CNT_W-1:0]  cycles_o
);
  logic [N_ACC-1:0]             act_in;
  logic [N_ACC-1:0][BANK_W-1:0] bank_in;
  logic [N_ACC-1:0]             pend_q;
  logic [N_ACC-1:0][BANK_W-1:0] bank_q;
  logic [N_ACC-1:0]             gnt;
  logic [N_ACC-1:0]             pend_nxt;
  logic [CNT_W-1:0]             cnt_in;
  logic [CNT_W-1:0]             cycles_q;
  logic                         accept;
  logic                         active;
  logic                         last;

  always_comb begin
    act_in          = '0;
    act_in[ACC_D0]  = 1'b1;
    act_in[ACC_D1]  = dual_i;
    act_in[ACC_IF]  = !ic_hit_i;
    bank_in         = '0;
    bank_in[ACC_D0] = d0_bank_i;
    bank_in[ACC_D1] = d1_bank_i;
    bank_in[ACC_IF] = fetch_bank_i;
  end

  sbc_conflict_count #(.BANK_W(BANK_W)) u_count (
    .act_i  (act_in),
    .bank_i (bank_in),
    .cnt_o  (cnt_in)
  );

  sbc_grant_arb #(.BANK_W(BANK_W)) u_arb (
    .pend_i (pend_q),
    .bank_i (bank_q),
    .gnt_o  (gnt)
  );

  assign active   = |pend_q;
  assign accept   = req_i && !active;
  assign pend_nxt = pend_q & ~gnt;
  assign last     = active && (pend_nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      bank_q   <= '0;
      cycles_q <= '0;
    end else if (accept) begin
      pend_q   <= act_in;
      bank_q   <= bank_in;
      cycles_q <= cnt_in;
    end else begin
      pend_q   <= pend_nxt;
    end
  end

  assign ready_o     = !active;
  assign stall_o     = active && !last;
  assign done_o      = last;
  assign d0_gnt_o    = gnt[ACC_D0];
  assign d1_gnt_o    = gnt[ACC_D1];
  assign fetch_gnt_o = gnt[ACC_IF];
  assign cycles_o    = cycles_q;

  // service cycle counter for the length check
  logic [CNT_W-1:0] svc_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       svc_cnt <= '0;
    else if (!active)  svc_cnt <= '0;
    else               svc_cnt <= svc_cnt + CNT_W'(1);
  end

  for (genvar i = 0; i < N_ACC; i++) begin : g_pair_i
    for (genvar j = i + 1; j < N_ACC; j++) begin : g_pair_j
      AST_ONE_PER_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt[i] && gnt[j]) |-> (bank_q[i] != bank_q[j])); // R3
    end
  end

  AST_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (CNT_W'(svc_cnt + CNT_W'(1)) == cycles_o)); // R6

  AST_STALL_XOR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (stall_o != done_o)); // R6

  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o); // R6

  AST_PROGRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (gnt != '0)); // R7

  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !last) |=> (!ready_o && $stable(cycles_o))); // R1

  AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (cycles_o != '0)); // R4
endmodule

// File: tb/tb_sbc_stall_seq.sv
`timescale 1ns/1ps
module tb_sbc_stall_seq;
  localparam int BANK_W = 2;
  localparam int NB     = 1 << BANK_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, dual_i = 1'b0, ic_hit_i = 1'b0;
  logic [BANK_W-1:0] fetch_bank_i = '0, d0_bank_i = '0, d1_bank_i = '0;
  logic              ready_o, stall_o, done_o, d0_gnt_o, d1_gnt_o, fetch_gnt_o;
  logic [1:0]        cycles_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sbc_stall_seq #(.BANK_W(BANK_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .dual_i(dual_i),
    .ic_hit_i(ic_hit_i), .fetch_bank_i(fetch_bank_i), .d0_bank_i(d0_bank_i),
    .d1_bank_i(d1_bank_i), .ready_o(ready_o), .stall_o(stall_o),
    .done_o(done_o), .d0_gnt_o(d0_gnt_o), .d1_gnt_o(d1_gnt_o),
    .fetch_gnt_o(fetch_gnt_o), .cycles_o(cycles_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input bit dual, input bit hit, input int fb,
                          input int b0, input int b1, input bit noise);
    bit [2:0] pend;
    int       bank [3];
    int       exp_cyc;
    int       mult;
    string    tg;
    exp_cyc = 0;
    pend    = {~hit, dual, 1'b1};
    bank[0] = b0; bank[1] = b1; bank[2] = fb;
    for (int i = 0; i < 3; i++) begin
      mult = 0;
      for (int j = 0; j < 3; j++)
        if (pend[i] && pend[j] && bank[i] == bank[j]) mult++;
      if (mult > exp_cyc) exp_cyc = mult;
    end
    tg = noise ? "R1 R5" : "R5";

    @(negedge clk);
    chk(ready_o == 1'b1, "R1 ready before request", int'(ready_o), 1);
    req_i = 1'b1; dual_i = dual; ic_hit_i = hit;
    fetch_bank_i = BANK_W'(fb); d0_bank_i = BANK_W'(b0); d1_bank_i = BANK_W'(b1);
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      dual_i = ~dual; ic_hit_i = ~hit;
      fetch_bank_i = BANK_W'(b0); d0_bank_i = BANK_W'(fb + 1); d1_bank_i = BANK_W'(b0);
    end else begin
      req_i = 1'b0;
    end
    chk(int'(cycles_o) == exp_cyc, "R4 cycles", int'(cycles_o), exp_cyc);
    for (int cyc = 1; cyc <= 3; cyc++) begin
      bit [2:0] eg;
      bit [NB-1:0] used;
      bit last;
      eg = '0; used = '0;
      for (int i = 0; i < 3; i++)
        if (pend[i] && !used[bank[i]]) begin eg[i] = 1'b1; used[bank[i]] = 1'b1; end
      pend = pend & ~eg;
      last = (pend == 0);
      chk({fetch_gnt_o, d1_gnt_o, d0_gnt_o} == eg,
          {tg, " R2 R3 R7 grants"}, int'({fetch_gnt_o, d1_gnt_o, d0_gnt_o}), int'(eg));
      chk(stall_o == !last, noise ? "R1 R6 stall" : "R6 stall", int'(stall_o), int'(!last));
      chk(done_o == last, "R6 done", int'(done_o), int'(last));
      chk(int'(cycles_o) == exp_cyc, noise ? "R1 R4 held" : "R4 held", int'(cycles_o), exp_cyc);
      if (last) begin
        chk(cyc == exp_cyc, "R6 length", cyc, exp_cyc);
        break;
      end
      @(posedge clk);
      @(negedge clk);
    end
    req_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(ready_o == 1'b1 && stall_o == 1'b0 && done_o == 1'b0,
        "R6 idle after done", int'({ready_o, stall_o, done_o}), 4);
    chk({fetch_gnt_o, d1_gnt_o, d0_gnt_o} == 3'b000, "R2 no grant idle",
        int'({fetch_gnt_o, d1_gnt_o, d0_gnt_o}), 0);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ready_o == 1'b1, "R8 ready reset", int'(ready_o), 1);
    chk(stall_o == 1'b0 && done_o == 1'b0, "R8 stall done reset", int'({stall_o, done_o}), 0);
    chk({fetch_gnt_o, d1_gnt_o, d0_gnt_o} == 3'b000, "R8 grants reset",
        int'({fetch_gnt_o, d1_gnt_o, d0_gnt_o}), 0);
    chk(cycles_o == 2'd0, "R8 cycles reset", int'(cycles_o), 0);
    rst_ni = 1'b1;
    n = 0;
    for (int d = 0; d < 2; d++)
      for (int h = 0; h < 2; h++)
        for (int f = 0; f < NB; f++)
          for (int a = 0; a < NB; a++)
            for (int b = 0; b < NB; b++) begin
              run_case(d[0], h[0], f, a, b, n[0]);
              n++;
            end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule